// File: doc/BRIEF.md
# Write-Through Store Queue with Read-Miss Bypass

This block sits between a write-through data cache and the memory port. Every store the cache writes through is placed in a small first-in first-out queue. The queue then drains to memory one word at a time whenever the port is otherwise idle. A read miss does not have to wait behind those stores. It is handed to memory ahead of any queued write. Before that happens, one of two selectable policies keeps the read from returning data that a pending store has already replaced.

With `chk_mode` high (forward policy), the read word address is compared with every valid queue entry. On a match, the data of the youngest matching store is returned in the same cycle, and no memory read takes place. With no match, the read goes to memory straight away, even while stores are still queued. With `chk_mode` low (drain-first policy), the read is held until the queue is empty. Draining continues while the read waits, and the read is then issued.

A single request/grant port carries both reads and drained writes. A write completes on its grant. A read completes when `mem_rvalid` returns its data. The read side is tracked by a four-state machine:
- RS_IDLE: no read outstanding.
- RS_HOLD: drain-first read waiting for the queue to empty.
- RS_ISSUE: read requested, grant not yet seen.
- RS_WAIT: read granted, data not yet returned.

The transitions are:
- IDLE→IDLE: forward hit.
- IDLE→ISSUE: read clear to go, no grant in that cycle.
- IDLE→WAIT: read clear to go, granted in the same cycle.
- IDLE→HOLD: drain-first read with the queue not empty.
- HOLD→ISSUE and HOLD→WAIT: the queue has become empty.
- ISSUE→WAIT: grant.
- WAIT→IDLE: data returned.

The queue depth must be a power of two, at least 2.

Top module: `wbuf_read_bypass`

## Requirements
- R1: After reset the queue is empty. `st_stall`, `mem_req` and `rd_done` are low.
- R2: A store accepted while `st_stall` is low is written to memory as a write request (`mem_we`=1) carrying its word address and data. Stores are written in arrival order. An entry leaves the queue on the clock edge where its write request is granted.
- R3: When all 4 entries are valid, `st_stall` is high and a store presented in that state is dropped. `st_stall` falls in the cycle after one write is granted.
- R4: When a read is clear to go and stores are queued, the port carries the read (`mem_we`=0, `mem_addr`=`rd_addr`) in that cycle, ahead of any drain.
- R5: In forward mode, a read whose address matches a queued store gets `rd_done`=1 and `rd_from_buf`=1 in the same cycle. `rd_data` is the data of the youngest matching store, and no memory read is requested.
- R6: In forward mode, a read with no match is requested from memory at once. It finishes with `rd_done`=1, `rd_from_buf`=0 and `rd_data`=`mem_rdata` in the cycle `mem_rvalid` is high.
- R7: In drain-first mode, no memory read is requested while any entry is valid. Queued writes keep draining, and the read then returns memory data that already includes those writes.
- R8: A read request stays on the port, with its address, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_mode | input | 1 | 1 = forward policy, 0 = drain-first policy |
| st_valid | input | 1 | Store present |
| st_addr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_stall | output | 1 | Queue full, store not taken |
| rd_req | input | 1 | Read miss pending, held until rd_done |
| rd_addr | input | 30 | Read word address |
| rd_done | output | 1 | Read data valid this cycle |
| rd_from_buf | output | 1 | Read data came from the queue |
| rd_data | output | 32 | Read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write (drain), 0 = read |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data from memory |

## Verification
The assertions take for granted that a requester holds `rd_req` and `rd_addr` steady up to and including the edge where `rd_done` is high, and that `chk_mode` does not change while a read is open. They also assume memory raises `mem_rvalid` only once per granted read, in a later cycle. The bench drives all inputs on falling edges. It lowers `rd_req` only on the falling edge after it sees `rd_done`, and changes the mode only between reads after a reset. Its memory model answers each read grant with a single `mem_rvalid` pulse one cycle later.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_HOLD  = 2'd1,
        RS_ISSUE = 2'd2,
        RS_WAIT  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/wbq_store_fifo.sv
module wbq_store_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 30,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] look_addr,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          hit,
    output logic [DW-1:0] hit_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DEPTH-1:0] vld_q;
    logic [PTR_W-1:0] head_q, tail_q;
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];

    assign full      = &vld_q;
    assign empty     = ~|vld_q;
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) begin
                vld_q[tail_q] <= 1'b1;
                tail_q        <= tail_q + 1'b1;
            end
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= head_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail_q] <= push_addr;
            data_q[tail_q] <= push_data;
        end
    end

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        logic [PTR_W-1:0] slot;
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head_q + PTR_W'(k);
            if (vld_q[slot] && addr_q[slot] == look_addr) begin
                hit      = 1'b1;
                hit_data = data_q[slot];
            end
        end
    end

    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));
endmodule

// File: rtl/wbq_ctrl.sv
module wbq_ctrl
    import wbq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic chk_mode,
    input  logic buf_hit,
    input  logic buf_empty,
    input  logic mem_gnt,
    input  logic mem_rvalid,
    output logic issue_rd,
    output logic drain_req,
    output logic fwd_hit,
    output logic mem_done,
    output logic rs_idle
);
    rd_state_e state_q, state_d;
    logic      read_clear;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        issue_rd   = 1'b0;
        fwd_hit    = 1'b0;
        mem_done   = 1'b0;
        rs_idle    = 1'b0;
        read_clear = chk_mode ? !buf_hit : buf_empty;
        unique case (state_q)
            RS_IDLE: begin
                rs_idle = 1'b1;
                if (rd_req) begin
                    if (chk_mode && buf_hit) begin
                        fwd_hit = 1'b1;
                    end else if (read_clear) begin
                        issue_rd = 1'b1;
                        state_d  = mem_gnt ? RS_WAIT : RS_ISSUE;
                    end else begin
                        state_d = RS_HOLD;
                    end
                end
            end
            RS_HOLD: begin
                if (buf_empty) begin
                    issue_rd = 1'b1;
                    state_d  = mem_gnt ? RS_WAIT : RS_ISSUE;
                end
            end
            RS_ISSUE: begin
                issue_rd = 1'b1;
                if (mem_gnt) state_d = RS_WAIT;
            end
            RS_WAIT: begin
                if (mem_rvalid) begin
                    mem_done = 1'b1;
                    state_d  = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
        drain_req = !buf_empty && !issue_rd && (state_q != RS_WAIT);
    end

    assert_hold_until_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_rd && !mem_gnt) |=> issue_rd);
endmodule

// File: rtl/wbuf_read_bypass.sv
module wbuf_read_bypass #(
    parameter int DEPTH = 4,
    parameter int AW    = 30,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_mode,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_stall,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_done,
    output logic          rd_from_buf,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    logic          buf_full, buf_empty, buf_hit;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data, hit_data;
    logic          issue_rd, drain_req, fwd_hit, mem_done, rs_idle;
    logic          do_push, do_pop;

    assign st_stall = buf_full;
    assign do_push  = st_valid && !buf_full;
    assign do_pop   = drain_req && mem_gnt;

    wbq_store_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (do_pop),
        .look_addr (rd_addr),
        .full      (buf_full),
        .empty     (buf_empty),
        .head_addr (head_addr),
        .head_data (head_data),
        .hit       (buf_hit),
        .hit_data  (hit_data)
    );

    wbq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .chk_mode   (chk_mode),
        .buf_hit    (buf_hit),
        .buf_empty  (buf_empty),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .issue_rd   (issue_rd),
        .drain_req  (drain_req),
        .fwd_hit    (fwd_hit),
        .mem_done   (mem_done),
        .rs_idle    (rs_idle)
    );

    assign mem_req     = issue_rd || drain_req;
    assign mem_we      = !issue_rd;
    assign mem_addr    = issue_rd ? rd_addr : head_addr;
    assign mem_wdata   = head_data;
    assign rd_done     = fwd_hit || mem_done;
    assign rd_from_buf = fwd_hit;
    assign rd_data     = fwd_hit ? hit_data : mem_rdata;

    assert_read_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && chk_mode && !buf_hit && rs_idle) |-> (mem_req && !mem_we));

    assert_fwd_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_from_buf |-> !(mem_req && !mem_we));

    assert_wait_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !chk_mode && !$past(mem_req && !mem_we)) |-> buf_empty);

    assert_read_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_gnt) |=> (mem_req && !mem_we));
endmodule

// File: tb/wbuf_read_bypass_tb.sv
module wbuf_read_bypass_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_mode = 1'b1;
    logic        st_valid = 1'b0;
    logic [29:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        st_stall;
    logic        rd_req = 1'b0;
    logic [29:0] rd_addr = '0;
    logic        rd_done, rd_from_buf;
    logic [31:0] rd_data;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        gnt_en = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [16];
    logic [29:0] log_addr [16];
    logic [31:0] log_data [16];
    int          log_n = 0;
    logic        rd_pend = 1'b0;
    logic [29:0] rd_pend_addr = '0;

    always #2.5 clk = ~clk;

    wbuf_read_bypass u_dut (
        .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
        .rd_from_buf(rd_from_buf), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(gnt_en), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Memory model: acts half a nanosecond after each falling edge.
    always @(negedge clk) begin
        #0.5;
        if (rd_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[rd_pend_addr[7:4]];
            rd_pend    = 1'b0;
        end else begin
            mem_rvalid = 1'b0;
        end
        if (rst_n && mem_req && gnt_en) begin
            if (mem_we) begin
                mem[mem_addr[7:4]] = mem_wdata;
                if (log_n < 16) begin
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_wdata;
                end
                log_n++;
            end else begin
                rd_pend      = 1'b1;
                rd_pend_addr = mem_addr;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_req = 1'b0; st_valid = 1'b0; gnt_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 | (i << 4);
        log_n = 0; rd_pend = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [29:0] a, input logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // {mode(1), addr(30), hit(1), data(32)}
    localparam logic [63:0] VEC [6] = '{
        {1'b1, 30'h10, 1'b1, 32'h3333_3333},
        {1'b1, 30'h20, 1'b1, 32'h2222_2222},
        {1'b1, 30'h30, 1'b0, 32'hC0DE_0030},
        {1'b0, 30'h20, 1'b0, 32'h2222_2222},
        {1'b0, 30'h40, 1'b0, 32'hC0DE_0040},
        {1'b0, 30'h10, 1'b0, 32'h3333_3333}
    };

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk(st_stall == 1'b0, "R1 stall after reset", st_stall, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
        chk(rd_done == 1'b0, "R1 rd_done after reset", rd_done, 0);

        // Vector table: three stores, then one read per vector
        for (int v = 0; v < 6; v++) begin
            logic        vm, vh, got;
            logic [29:0] va;
            logic [31:0] vd;
            vm = VEC[v][63]; va = VEC[v][62:33]; vh = VEC[v][32]; vd = VEC[v][31:0];
            do_reset();
            chk_mode = vm;
            push(30'h10, 32'h1111_1111);
            push(30'h20, 32'h2222_2222);
            push(30'h10, 32'h3333_3333);
            rd_req = 1'b1; rd_addr = va;
            #1;
            got = 1'b0;
            if (vh) begin
                chk(rd_done && rd_from_buf, "R5 forward same cycle", {rd_done, rd_from_buf}, 2'b11);
                chk(rd_data == vd, "R5 youngest data", rd_data, vd);
                chk(!(mem_req && !mem_we), "R5 no memory read", mem_req, 0);
                got = 1'b1;
            end else begin
                if (vm) begin
                    chk(mem_req && !mem_we && mem_addr == va, "R4 read ahead of drain", mem_addr, va);
                    repeat (2) begin
                        @(negedge clk); #1;
                        chk(mem_req && !mem_we && mem_addr == va, "R8 read held", mem_addr, va);
                    end
                end else begin
                    chk(mem_req && mem_we && mem_addr == 30'h10, "R7 drain while held", mem_addr, 30'h10);
                end
                @(negedge clk);
                gnt_en = 1'b1;
                for (int c = 0; c < 40 && !got; c++) begin
                    #1;
                    if (!vm && mem_req && !mem_we)
                        chk(log_n == 3, "R7 read only after empty", log_n, 3);
                    if (rd_done) begin
                        got = 1'b1;
                        chk(rd_data == vd, vm ? "R6 memory data" : "R7 memory data", rd_data, vd);
                        chk(rd_from_buf == 1'b0, "R6 not from queue", rd_from_buf, 0);
                    end else begin
                        @(negedge clk);
                    end
                end
            end
            chk(got, "R6 read completed", got, 1);
            @(negedge clk);
            rd_req = 1'b0; gnt_en = 1'b0;
        end

        // R3 / R2: fill, stall, dropped store, drain order
        do_reset();
        chk_mode = 1'b1;
        for (int i = 0; i < 4; i++) push(30'h50 + 30'(i * 16), 32'hD0 + 32'(i));
        #1;
        chk(st_stall == 1'b1, "R3 stall when full", st_stall, 1);
        @(negedge clk);
        push(30'h90, 32'hDEAD_BEEF);
        #1;
        chk(st_stall == 1'b1, "R3 still stalled", st_stall, 1);
        @(negedge clk);
        gnt_en = 1'b1;
        #1;
        chk(mem_req && mem_we && mem_addr == 30'h50, "R2 head drains first", mem_addr, 30'h50);
        @(negedge clk);
        gnt_en = 1'b0;
        #1;
        chk(st_stall == 1'b0, "R3 stall clears after one drain", st_stall, 0);
        @(negedge clk);
        gnt_en = 1'b1;
        repeat (8) @(negedge clk);
        gnt_en = 1'b0;
        #1;
        chk(log_n == 4, "R3 dropped store not written", log_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_addr[i] == 30'h50 + 30'(i * 16), "R2 write order addr", log_addr[i], 30'h50 + 30'(i * 16));
            chk(log_data[i] == 32'hD0 + 32'(i), "R2 write order data", log_data[i], 32'hD0 + 32'(i));
        end
        chk(mem_req == 1'b0, "R2 queue empty after drain", mem_req, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule